// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This block is a bus master that owns a byte-wide, command-driven flash device for one bank. On an erase request it sends the two-byte erase command and waits until the device reports that it is ready. On a write request it programs the bank one byte at a time, in ascending address order, from a source memory, and waits for the device after every byte. Every wait is a loop of status reads with an upper limit on the number of reads.

After either operation the block clears the device status and returns the device to array-read mode. It then reads the whole bank back and compares each byte against the expected value: 0xFF after an erase, or the source byte after a write.

A single `done` pulse ends the operation. Three separate flags report the outcome: a poll limit was reached, the read-back did not match, or the device reported an error in its status register. The flags hold until the next operation starts.

Top module: `flash_bank_prog`

## Requirements
- R1: While reset is held and after it is released, the block is idle. `busy`, `done`, all three error flags, `fl_we`, `fl_re` and `src_re` are low.
- R2: An erase writes command 0x20 and then command 0xD0 to flash address 0, on two consecutive cycles.
- R3: A status poll writes 0x70 to address 0 and then reads address 0. The wait ends when bit 7 of the returned byte is 1. The number of 0x70 writes in one wait is the number of not-ready reads plus one.
- R4: A write programs the bank bytes from address 0 upward. For each byte the block writes 0x40 to that byte's address. Exactly SETUP_WAIT+1 cycles later it writes the source byte to the same address. It then polls status before the next byte.
- R5: One wait issues at most POLL_MAX status reads. If none of them shows bit 7 set, `err_timeout` is raised and the wait ends. During a write, the remaining bytes are then skipped.
- R6: Every operation, including one that timed out, ends its command phase with 0x50 and then 0xFF to address 0 on consecutive cycles.
- R7: After an erase, `err_verify` is raised unless every byte of the bank reads back as 0xFF.
- R8: After a write, `err_verify` is raised unless every byte of the bank reads back equal to the source byte at the same address.
- R9: A ready status (bit 7 = 1) that also has any of bits 5..3 set (mask 0x38) raises `err_device`. The operation still runs to completion.
- R10: `done` is high for exactly one cycle, after read-back. `busy` is high from the cycle after a start is accepted until `done`. The error flags clear when a start is accepted and hold their value after `done`.
- R11: Start inputs are ignored while `busy` is high. If both starts are high in the same idle cycle, an erase is performed.
- R12: `fl_we` and `fl_re` are never high together. A write to a nonzero flash address happens only as the 0x40 command or the data byte of programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_erase | input | 1 | Request a bank erase (sampled while idle) |
| start_write | input | 1 | Request bank programming from the source (sampled while idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_timeout | output | 1 | A status wait hit the poll limit |
| err_verify | output | 1 | Read-back differed from the expected bank contents |
| err_device | output | 1 | Device status showed an error bit (mask 0x38) |
| fl_addr | output | ADDR_W | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write data or command byte |
| fl_we | output | 1 | Flash write strobe, one cycle per byte |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| src_addr | output | ADDR_W | Source image byte address |
| src_re | output | 1 | Source read strobe |
| src_rdata | input | 8 | Source data, valid the cycle after `src_re` |

## Verification
The assertions assume that both the flash and the source memory return read data exactly one cycle after the strobe. They also assume the flash answers every read at address 0 taken after a 0x70 command with its status byte. The start inputs are assumed to be pulses that may arrive at any time, including while the block is busy.

The bench's flash model follows these timing rules. Its behaviour is set per scenario: the number of not-ready status reads, a device that never becomes ready, status error bits, and a cell that cannot be erased. Programming uses AND semantics, so writing without a prior erase produces a real mismatch. The starts are driven at the falling edge, so every scenario stays inside the assumed input behaviour.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
   localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
   localparam logic [7:0] CMD_PROG_BYTE  = 8'h40;
   localparam logic [7:0] CMD_STAT_READ  = 8'h70;
   localparam logic [7:0] CMD_STAT_CLR   = 8'h50;
   localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
   localparam int         RDY_BIT        = 7;
   localparam logic [7:0] FAULT_MASK     = 8'h38;
   localparam logic [7:0] BLANK_BYTE     = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ERASE_ARM, ST_ERASE_GO, ST_PROG_CMD, ST_PROG_WAIT,
      ST_PROG_DATA, ST_STAT_CMD, ST_STAT_RD, ST_STAT_CHK, ST_CLR,
      ST_ARRAY, ST_VFY_RD, ST_VFY_CHK, ST_DONE
   } fbp_state_e;
endpackage

// File: rtl/fbp_cycle_timer.sv
module fbp_cycle_timer #(
   parameter int WAIT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int            CW     = (WAIT > 1) ? $clog2(WAIT) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(WAIT - 1);

   generate
      if (WAIT < 1) begin : g_bad_wait
         $error("fbp_cycle_timer: WAIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= RELOAD;
      else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R4
   tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);
endmodule

// File: rtl/fbp_poll_limit.sv
module fbp_poll_limit #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic reached
);
   localparam int           W   = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("fbp_poll_limit: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clear)              cnt_q <= '0;
      else if (step && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q == LIM);

   // R5
   poll_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);
endmodule

// File: rtl/fbp_byte_check.sv
module fbp_byte_check (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       en,
   input  logic [7:0] actual,
   input  logic [7:0] expected,
   output logic       mismatch
);
   logic miss_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        miss_q <= 1'b0;
      else if (clear)                    miss_q <= 1'b0;
      else if (en && actual != expected) miss_q <= 1'b1;
   end

   assign mismatch = miss_q;

   // R8
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_q && !clear) |=> miss_q);
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
   import fbp_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int SETUP_WAIT = 50,
   parameter int POLL_MAX   = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_erase,
   input  logic              start_write,
   output logic              busy,
   output logic              done,
   output logic              err_timeout,
   output logic              err_verify,
   output logic              err_device,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   output logic              fl_we,
   output logic              fl_re,
   input  logic [7:0]        fl_rdata,
   output logic [ADDR_W-1:0] src_addr,
   output logic              src_re,
   input  logic [7:0]        src_rdata
);
   localparam logic [ADDR_W-1:0] LAST_IDX = '1;
   localparam logic [ADDR_W-1:0] BASE     = '0;

   generate
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_aw
         $error("flash_bank_prog: ADDR_W out of range");
      end
   endgenerate

   fbp_state_e        state_q, state_d;
   logic [ADDR_W-1:0] idx_q;
   logic              op_wr_q, cap_pend_q;
   logic [7:0]        src_byte_q;
   logic              err_to_q, err_dev_q;

   logic accept, idx_clr, idx_inc, poll_clr, poll_step;
   logic tmr_load, tmr_run, tmr_exp, poll_hit;
   logic chk_en, to_set, dev_set, stat_rdy;
   logic [7:0] vfy_expect;

   assign stat_rdy   = fl_rdata[RDY_BIT];
   assign vfy_expect = op_wr_q ? src_rdata : BLANK_BYTE;

   always_comb begin
      state_d   = state_q;
      accept    = 1'b0;
      idx_clr   = 1'b0;
      idx_inc   = 1'b0;
      poll_clr  = 1'b0;
      poll_step = 1'b0;
      tmr_load  = 1'b0;
      tmr_run   = 1'b0;
      chk_en    = 1'b0;
      to_set    = 1'b0;
      dev_set   = 1'b0;
      fl_addr   = BASE;
      fl_wdata  = '0;
      fl_we     = 1'b0;
      fl_re     = 1'b0;
      src_addr  = idx_q;
      src_re    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_erase || start_write) begin
               accept  = 1'b1;
               idx_clr = 1'b1;
               state_d = start_erase ? ST_ERASE_ARM : ST_PROG_CMD;
            end
         end
         ST_ERASE_ARM: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_ERASE_ARM;
            state_d  = ST_ERASE_GO;
         end
         ST_ERASE_GO: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_ERASE_GO;
            poll_clr = 1'b1;
            state_d  = ST_STAT_CMD;
         end
         ST_PROG_CMD: begin
            fl_we    = 1'b1;
            fl_addr  = idx_q;
            fl_wdata = CMD_PROG_BYTE;
            src_re   = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_PROG_WAIT;
         end
         ST_PROG_WAIT: begin
            tmr_run = 1'b1;
            if (tmr_exp) state_d = ST_PROG_DATA;
         end
         ST_PROG_DATA: begin
            fl_we    = 1'b1;
            fl_addr  = idx_q;
            fl_wdata = src_byte_q;
            poll_clr = 1'b1;
            state_d  = ST_STAT_CMD;
         end
         ST_STAT_CMD: begin
            fl_we     = 1'b1;
            fl_wdata  = CMD_STAT_READ;
            poll_step = 1'b1;
            state_d   = ST_STAT_RD;
         end
         ST_STAT_RD: begin
            fl_re   = 1'b1;
            state_d = ST_STAT_CHK;
         end
         ST_STAT_CHK: begin
            if (stat_rdy) begin
               dev_set = |(fl_rdata & FAULT_MASK);
               if (op_wr_q && idx_q != LAST_IDX) begin
                  idx_inc = 1'b1;
                  state_d = ST_PROG_CMD;
               end else begin
                  state_d = ST_CLR;
               end
            end else if (poll_hit) begin
               to_set  = 1'b1;
               state_d = ST_CLR;
            end else begin
               state_d = ST_STAT_CMD;
            end
         end
         ST_CLR: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_STAT_CLR;
            state_d  = ST_ARRAY;
         end
         ST_ARRAY: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_ARRAY_MODE;
            idx_clr  = 1'b1;
            state_d  = ST_VFY_RD;
         end
         ST_VFY_RD: begin
            fl_re   = 1'b1;
            fl_addr = idx_q;
            src_re  = op_wr_q;
            state_d = ST_VFY_CHK;
         end
         ST_VFY_CHK: begin
            chk_en = 1'b1;
            if (idx_q == LAST_IDX) begin
               state_d = ST_DONE;
            end else begin
               idx_inc = 1'b1;
               state_d = ST_VFY_RD;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         op_wr_q    <= 1'b0;
         cap_pend_q <= 1'b0;
         src_byte_q <= '0;
         err_to_q   <= 1'b0;
         err_dev_q  <= 1'b0;
      end else begin
         state_q    <= state_d;
         cap_pend_q <= (state_q == ST_PROG_CMD);
         if (idx_clr)      idx_q <= '0;
         else if (idx_inc) idx_q <= idx_q + 1'b1;
         if (accept)       op_wr_q <= !start_erase;
         if (cap_pend_q)   src_byte_q <= src_rdata;
         if (accept)       err_to_q <= 1'b0;
         else if (to_set)  err_to_q <= 1'b1;
         if (accept)       err_dev_q <= 1'b0;
         else if (dev_set) err_dev_q <= 1'b1;
      end
   end

   fbp_cycle_timer #(.WAIT(SETUP_WAIT)) u_setup_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
      .expired(tmr_exp)
   );

   fbp_poll_limit #(.LIMIT(POLL_MAX)) u_poll (
      .clk(clk), .rst_n(rst_n), .clear(poll_clr), .step(poll_step),
      .reached(poll_hit)
   );

   fbp_byte_check u_vfy (
      .clk(clk), .rst_n(rst_n), .clear(accept), .en(chk_en),
      .actual(fl_rdata), .expected(vfy_expect), .mismatch(err_verify)
   );

   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign err_timeout = err_to_q;
   assign err_device  = err_dev_q;

   // R12
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));
   // R12
   base_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we && fl_addr != BASE) |->
         (state_q == ST_PROG_CMD || state_q == ST_PROG_DATA));
   // R4
   wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROG_DATA) |-> $past(tmr_exp));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R11
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(op_wr_q));
   // R6
   clr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CLR) |=> (fl_we && fl_wdata == CMD_ARRAY_MODE));
endmodule

// File: tb/flash_bank_prog_bench.sv
module flash_bank_prog_bench;
   localparam int AW = 4;
   localparam int N  = 1 << AW;
   localparam int SW = 3;
   localparam int PM = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_erase = 1'b0, start_write = 1'b0;
   logic busy, done, err_timeout, err_verify, err_device;
   logic [AW-1:0] fl_addr, src_addr;
   logic [7:0] fl_wdata, fl_rdata, src_rdata;
   logic fl_we, fl_re, src_re;

   always #10 clk = ~clk;

   flash_bank_prog #(.ADDR_W(AW), .SETUP_WAIT(SW), .POLL_MAX(PM)) u_flash_bank_prog (
      .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_write(start_write),
      .busy(busy), .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
      .err_device(err_device), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
      .fl_re(fl_re), .fl_rdata(fl_rdata), .src_addr(src_addr), .src_re(src_re),
      .src_rdata(src_rdata)
   );

   // flash and source models
   logic [7:0] mem [N];
   logic [7:0] src [N];
   bit stat_mode = 0, stuck = 0, want_data = 0, done_prev = 0;
   int busy_cfg = 0, busy_left = 0, bad_cell = -1;
   logic [7:0] err_bits = 8'h00;
   int cyc = 0, setup_cyc = 0, last_cmd_cyc = 0;
   logic [7:0] last_cmd = 8'h00;
   logic [AW-1:0] setup_addr = '0;
   int n20, nd0, n40, n70, n50, nff, seq_err, gap_bad, order_bad, done_long;
   int total = 0, bad = 0;

   initial fl_rdata = 8'h00;
   initial src_rdata = 8'h00;

   always @(posedge clk) begin
      if (src_re) src_rdata <= src[src_addr];
      if (done && done_prev) done_long++;
      done_prev = done;
      if (fl_re) begin
         if (!stat_mode)          fl_rdata <= mem[fl_addr];
         else if (stuck)          fl_rdata <= 8'h00;
         else if (busy_left > 0) begin busy_left--; fl_rdata <= 8'h00; end
         else                     fl_rdata <= 8'h80 | err_bits;
      end
      if (fl_we) begin
         if (want_data) begin
            want_data = 0;
            if (fl_addr != setup_addr) seq_err++;
            if (cyc - setup_cyc != SW + 1) gap_bad++;
            mem[fl_addr] = mem[fl_addr] & fl_wdata;
            busy_left = busy_cfg;
            stat_mode = 1;
         end else begin
            if (fl_wdata != 8'h40 && fl_addr != '0) seq_err++;
            case (fl_wdata)
               8'h20: n20++;
               8'hD0: begin
                  nd0++;
                  if (last_cmd != 8'h20 || last_cmd_cyc != cyc - 1) seq_err++;
                  for (int i = 0; i < N; i++) mem[i] = (i == bad_cell) ? 8'h00 : 8'hFF;
                  busy_left = busy_cfg;
                  stat_mode = 1;
               end
               8'h40: begin
                  if (int'(fl_addr) != n40) order_bad++;
                  n40++;
                  want_data = 1;
                  setup_addr = fl_addr;
                  setup_cyc = cyc;
               end
               8'h70: begin n70++; stat_mode = 1; end
               8'h50: n50++;
               8'hFF: begin
                  nff++;
                  if (last_cmd != 8'h50 || last_cmd_cyc != cyc - 1) seq_err++;
                  stat_mode = 0;
               end
               default: seq_err++;
            endcase
            last_cmd = fl_wdata;
            last_cmd_cyc = cyc;
         end
      end
      cyc++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      n20 = 0; nd0 = 0; n40 = 0; n70 = 0; n50 = 0; nff = 0;
      seq_err = 0; gap_bad = 0; order_bad = 0;
   endtask

   function automatic int count_not_ff();
      int c = 0;
      for (int i = 0; i < N; i++) if (mem[i] != 8'hFF) c++;
      return c;
   endfunction

   function automatic int count_not_src();
      int c = 0;
      for (int i = 0; i < N; i++) if (mem[i] != src[i]) c++;
      return c;
   endfunction

   task automatic wait_done();
      int k = 0;
      while (!done && k < 5000) begin @(negedge clk); k++; end
      chk(done, "R10 operation finished", int'(done), 1);
   endtask

   task automatic run_op(input bit e, input bit w);
      clear_counts();
      @(negedge clk);
      start_erase = e; start_write = w;
      @(negedge clk);
      start_erase = 0; start_write = 0;
      chk(busy, "R10 busy after start", int'(busy), 1);
      wait_done();
   endtask

   task automatic t_reset();
      chk(!busy && !done && !fl_we && !fl_re && !src_re, "R1 idle outputs",
          int'({busy, done, fl_we, fl_re, src_re}), 0);
      chk(!err_timeout && !err_verify && !err_device, "R1 error flags",
          int'({err_timeout, err_verify, err_device}), 0);
   endtask

   task automatic t_erase_ok();
      for (int i = 0; i < N; i++) mem[i] = 8'(i * 7 + 1);
      busy_cfg = 3;
      run_op(1, 0);
      chk(!err_verify && !err_timeout && !err_device, "R7 clean erase flags",
          int'({err_timeout, err_verify, err_device}), 0);
      chk(count_not_ff() == 0, "R7 bank blank", count_not_ff(), 0);
      chk(n20 == 1 && nd0 == 1 && seq_err == 0, "R2 erase command pair", seq_err, 0);
      chk(n70 == busy_cfg + 1, "R3 status polls", n70, busy_cfg + 1);
      chk(n50 == 1 && nff == 1, "R6 clear then reset", n50 + nff, 2);
   endtask

   task automatic t_write_ok();
      for (int i = 0; i < N; i++) src[i] = 8'(i * 37 + 5);
      busy_cfg = 2;
      run_op(0, 1);
      chk(!err_verify && !err_timeout, "R8 clean write flags",
          int'({err_timeout, err_verify}), 0);
      chk(count_not_src() == 0, "R8 bank equals source", count_not_src(), 0);
      chk(n40 == N && order_bad == 0, "R4 byte order", order_bad, 0);
      chk(gap_bad == 0 && seq_err == 0, "R4 setup wait gap", gap_bad, 0);
      chk(n70 == N * (busy_cfg + 1), "R3 polls per byte", n70, N * (busy_cfg + 1));
   endtask

   task automatic t_write_noerase();
      for (int i = 0; i < N; i++) src[i] = ~src[i];
      run_op(0, 1);
      chk(err_verify, "R8 mismatch flagged", int'(err_verify), 1);
      chk(!err_timeout, "R8 no timeout", int'(err_timeout), 0);
   endtask

   task automatic t_bad_cell();
      bad_cell = 5;
      run_op(1, 0);
      chk(err_verify, "R7 unerased cell flagged", int'(err_verify), 1);
      bad_cell = -1;
      run_op(1, 0);
      chk(!err_verify, "R10 flags cleared by new start", int'(err_verify), 0);
   endtask

   task automatic t_timeout_erase();
      stuck = 1;
      run_op(1, 0);
      chk(err_timeout, "R5 erase timeout", int'(err_timeout), 1);
      chk(n70 == PM, "R5 poll limit", n70, PM);
      chk(n50 == 1 && nff == 1 && seq_err == 0, "R6 finish after timeout", n50 + nff, 2);
      chk(!err_verify, "R7 blank after timeout erase", int'(err_verify), 0);
   endtask

   task automatic t_timeout_write();
      run_op(0, 1);
      chk(err_timeout, "R5 write timeout", int'(err_timeout), 1);
      chk(n40 == 1, "R5 byte loop aborted", n40, 1);
      chk(err_verify, "R8 partial write mismatch", int'(err_verify), 1);
      stuck = 0;
   endtask

   task automatic t_dev_err();
      err_bits = 8'h10;
      busy_cfg = 1;
      run_op(1, 0);
      chk(err_device, "R9 device error bit", int'(err_device), 1);
      chk(!err_timeout && count_not_ff() == 0, "R9 op completes", count_not_ff(), 0);
      chk(n70 == 2, "R9 polls unchanged", n70, 2);
      err_bits = 8'h00;
   endtask

   task automatic t_priority();
      run_op(1, 1);
      chk(n20 == 1 && n40 == 0, "R11 erase wins", n40, 0);
      chk(!err_device, "R10 device flag cleared", int'(err_device), 0);
   endtask

   task automatic t_busy_ignore();
      clear_counts();
      @(negedge clk); start_write = 1;
      @(negedge clk); start_write = 0;
      repeat (3) @(negedge clk);
      start_erase = 1;
      @(negedge clk); start_erase = 0;
      wait_done();
      chk(n20 == 0 && n40 == N, "R11 start ignored while busy", n20, 0);
      repeat (4) @(negedge clk);
      chk(!busy, "R11 no deferred start", int'(busy), 0);
      chk(done_long == 0, "R10 done single cycle", done_long, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_erase_ok();
      t_write_ok();
      t_write_noerase();
      t_bad_cell();
      t_timeout_erase();
      t_timeout_write();
      t_dev_err();
      t_priority();
      t_busy_ignore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule